// File: doc/BRIEF.md
# Cascadable Interrupt Aggregator

This block merges a bank of interrupt request lines into one wired interrupt. Each line is brought into the local clock domain and sensed either as an active-high level or as a rising edge. The sensing choice is a single setting shared by every line. A detected request latches a bit in a pending-cause register, and that bit stays set until software clears it. A mask register holds one enable per line. The wired output is high whenever any pending bit is not masked.

Software uses a small single-cycle register bus. It reads the pending causes, acknowledges them by writing zeros into the cause register, changes the mask, and selects the sensing mode. The output is an ordinary signal, so it can drive a parent interrupt controller or one input line of another copy of this block.

Top module: `irq_aggregator`

## Requirements
- R1: The cause register is at byte offset 0x00, the mask register at 0x10 and the control register at 0x28. A read returns its data on `rsp_rdata` after the next rising clock edge. A read from any other offset returns 0, and a write to any other offset changes no register.
- R2: After reset, cause is 0x00000000, mask is 0xFFFFFFFF, control is 0x00000000 and `irq_out` is low.
- R3: When control bit 3 is 0 (level mode), each input is sampled through a two-flop synchroniser. Cause bit i is set in every cycle in which synchronised input i is high. An input first seen high before clock edge k makes cause bit i visible after edge k+2.
- R4: When control bit 3 is 1 (edge mode), cause bit i is set only on a 0-to-1 transition of synchronised input i, with the same two-edge latency as in R3. An input that stays high does not set the bit again after it is cleared.
- R5: A write to the cause register clears each cause bit whose write-data bit is 0 and keeps each bit whose write-data bit is 1.
- R6: If a hardware set and a software clear reach the same cause bit in the same cycle, the bit ends up set.
- R7: A cause bit stays set once latched, even after its input goes low, until software clears it.
- R8: Mask bit i set to 1 blocks input i from `irq_out`, and 0 enables it. Masking does not stop cause bit i from latching. A write to the mask register loads all 32 bits.
- R9: `irq_out` is high exactly when the cause register AND the inverted mask register is non-zero. It follows register updates in the same cycle.
- R10: Only control bits 3 and 5 can be written and read back; every other control bit reads as 0. Bit 5 (alternate message path held off) has no effect on `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| irq_in | input | 32 | Interrupt source lines, may be asynchronous |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_out | output | 1 | Wired interrupt to parent or next stage |

## Verification
The assertions assume that reset is asserted from the first clock edge. They also assume that `req_addr` and `req_wdata` have meaning only in a cycle where `req_valid` is high, and that a request is held for a single cycle. The stimulus changes every input and bus signal half a period away from the active edge. Each access lasts exactly one cycle, and the source lines are randomised freely. A reference model in the bench follows the synchroniser and the cause rule in step with the design, so it can predict the result even when a software clear and a hardware set land together.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int unsigned CTRL_EDGE_BIT = 3;
   localparam int unsigned CTRL_HOLD_BIT = 5;
   localparam int unsigned OFS_CAUSE     = 32'h00;
   localparam int unsigned OFS_MASK      = 32'h10;
   localparam int unsigned OFS_CTRL      = 32'h28;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_CAUSE = 2'd1,
      SEL_MASK  = 2'd2,
      SEL_CTRL  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_agg_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] pipe_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
      end else begin
         pipe_q[0] <= async_in;
         for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
      end
   end

   assign sync_out = pipe_q[STAGES-1];
endmodule

// File: rtl/irq_agg_capture.sv
module irq_agg_capture #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_mode,
   input  logic [WIDTH-1:0] sync_in,
   output logic [WIDTH-1:0] set_vec
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_in;
   end

   always_comb begin
      if (edge_mode) set_vec = sync_in & ~prev_q;
      else           set_vec = sync_in;
   end

   // R4: in edge mode a line cannot raise a set request two cycles running
   a_r4_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && $past(edge_mode)) |-> ((set_vec & $past(set_vec)) == '0));
endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
   import irq_agg_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [N_SRC-1:0]  set_vec,
   output logic [N_SRC-1:0]  cause,
   output logic [N_SRC-1:0]  mask,
   output logic              edge_mode,
   output logic [DATA_W-1:0] rsp_rdata
);
   if (N_SRC != DATA_W) begin : g_bad_width
      $error("irq_agg_regs: N_SRC must equal DATA_W");
   end
   if (DATA_W <= CTRL_HOLD_BIT) begin : g_bad_ctrl
      $error("irq_agg_regs: DATA_W too narrow for control bits");
   end

   reg_sel_e          sel;
   logic              wr_cause, wr_mask, wr_ctrl, rd_en;
   logic [N_SRC-1:0]  cause_q, mask_q;
   logic              edge_q, hold_q;
   logic [DATA_W-1:0] ctrl_view, rd_mux;

   always_comb begin
      if (req_addr == ADDR_W'(OFS_CAUSE))     sel = SEL_CAUSE;
      else if (req_addr == ADDR_W'(OFS_MASK)) sel = SEL_MASK;
      else if (req_addr == ADDR_W'(OFS_CTRL)) sel = SEL_CTRL;
      else                                    sel = SEL_NONE;
   end

   assign wr_cause = req_valid && req_write && (sel == SEL_CAUSE);
   assign wr_mask  = req_valid && req_write && (sel == SEL_MASK);
   assign wr_ctrl  = req_valid && req_write && (sel == SEL_CTRL);
   assign rd_en    = req_valid && !req_write;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q <= '0;
         mask_q  <= '1;
         edge_q  <= 1'b0;
         hold_q  <= 1'b0;
      end else begin
         cause_q <= (wr_cause ? (cause_q & req_wdata) : cause_q) | set_vec;
         if (wr_mask) mask_q <= req_wdata;
         if (wr_ctrl) begin
            edge_q <= req_wdata[CTRL_EDGE_BIT];
            hold_q <= req_wdata[CTRL_HOLD_BIT];
         end
      end
   end

   always_comb begin
      ctrl_view                = '0;
      ctrl_view[CTRL_EDGE_BIT] = edge_q;
      ctrl_view[CTRL_HOLD_BIT] = hold_q;
      case (sel)
         SEL_CAUSE: rd_mux = cause_q;
         SEL_MASK:  rd_mux = mask_q;
         SEL_CTRL:  rd_mux = ctrl_view;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rsp_rdata <= '0;
      else if (rd_en) rsp_rdata <= rd_mux;
   end

   assign cause     = cause_q;
   assign mask      = mask_q;
   assign edge_mode = edge_q;

   // R6: a set request always leaves its bit set, whatever software wrote
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cause_q & $past(set_vec)) == $past(set_vec)));
   // R7: without a cause write no latched bit can drop
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cause |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
   // R5: a cause write with no competing set leaves exactly the kept bits
   a_r5_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cause && (set_vec == '0)) |=> (cause_q == $past(cause_q & req_wdata)));
   // R8: a mask write loads the full word
   a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask |=> (mask_q == $past(req_wdata)));
   // R1: unmapped reads give zero, unmapped writes leave mask and control alone
   a_r1_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && sel == SEL_NONE) |=> (rsp_rdata == '0));
   a_r1_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && sel == SEL_NONE) |=>
         ($stable(mask_q) && $stable(edge_q) && $stable(hold_q)));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
   parameter int unsigned N_SRC       = 32,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_in,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              irq_out
);
   logic [N_SRC-1:0] sync_in, set_vec, cause, mask;
   logic             edge_mode;

   irq_agg_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (irq_in),
      .sync_out (sync_in)
   );

   irq_agg_capture #(.WIDTH(N_SRC)) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .edge_mode (edge_mode),
      .sync_in   (sync_in),
      .set_vec   (set_vec)
   );

   irq_agg_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .set_vec   (set_vec),
      .cause     (cause),
      .mask      (mask),
      .edge_mode (edge_mode),
      .rsp_rdata (rsp_rdata)
   );

   assign irq_out = |(cause & ~mask);

   // R9: the output can only fall after software touched a register
   a_r9_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_out) |-> $past(req_valid && req_write));
   // R2: nothing pending can reach the output while every line is masked
   a_r2_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '1) |-> !irq_out);
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata;
   logic        irq_out;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   irq_aggregator dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .irq_out(irq_out)
   );

   // reference model built from the requirements
   logic [31:0] m_s1, m_s2, m_prev, m_cause, m_mask, m_ctrl, m_rdata;
   bit          m_rd_chk;

   function automatic logic [31:0] exp_read(input logic [31:0] a);
      if (a == 32'h00)      return m_cause;
      else if (a == 32'h10) return m_mask;
      else if (a == 32'h28) return m_ctrl;
      else                  return 32'h0;
   endfunction

   function automatic logic exp_irq();
      return |(m_cause & ~m_mask);
   endfunction

   always @(posedge clk) begin : model
      logic [31:0] setv, nc;
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
         m_cause <= '0; m_mask <= '1; m_ctrl <= '0;
         m_rdata <= '0; m_rd_chk <= 1'b0;
      end else begin
         m_s1 <= irq_in; m_s2 <= m_s1; m_prev <= m_s2;
         setv = m_ctrl[3] ? (m_s2 & ~m_prev) : m_s2;
         nc = m_cause;
         if (req_valid && req_write && req_addr == 32'h00) nc = nc & req_wdata;
         m_cause <= nc | setv;
         if (req_valid && req_write && req_addr == 32'h10) m_mask <= req_wdata;
         if (req_valid && req_write && req_addr == 32'h28) m_ctrl <= req_wdata & 32'h28;
         m_rd_chk <= req_valid && !req_write;
         if (req_valid && !req_write) m_rdata <= exp_read(req_addr);
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // continuous comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(irq_out == exp_irq(), "R9", {31'b0, irq_out}, {31'b0, exp_irq()});
         if (m_rd_chk) check(rsp_rdata == m_rdata, "R1", rsp_rdata, m_rdata);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      d = rsp_rdata;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] rd;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick(1);

      // R2 reset state
      check(irq_out == 1'b0, "R2 irq_out", {31'b0, irq_out}, 32'h0);
      bus_read(32'h00, rd); check(rd == 32'h0, "R2 cause", rd, 32'h0);
      bus_read(32'h10, rd); check(rd == 32'hFFFF_FFFF, "R2 mask", rd, 32'hFFFF_FFFF);
      bus_read(32'h28, rd); check(rd == 32'h0, "R2 ctrl", rd, 32'h0);

      // R1 unmapped offsets
      bus_write(32'h04, 32'h0);
      bus_write(32'h2C, 32'hFFFF_FFFF);
      bus_read(32'h10, rd); check(rd == 32'hFFFF_FFFF, "R1 unmapped write", rd, 32'hFFFF_FFFF);
      bus_read(32'h28, rd); check(rd == 32'h0, "R1 unmapped write ctrl", rd, 32'h0);
      bus_read(32'h14, rd); check(rd == 32'h0, "R1 unmapped read", rd, 32'h0);

      // R10 control bits
      bus_write(32'h28, 32'hFFFF_FFFF);
      bus_read(32'h28, rd); check(rd == 32'h28, "R10 ctrl bits", rd, 32'h28);
      bus_write(32'h28, 32'h20);
      bus_read(32'h28, rd); check(rd == 32'h20, "R10 hold bit", rd, 32'h20);

      // R3 level mode latency, with bit 5 held (R10 no effect)
      bus_write(32'h10, 32'h0);
      irq_in = 32'h10;
      tick(2); check(irq_out == 1'b0, "R3 before latency", {31'b0, irq_out}, 32'h0);
      tick(1); check(irq_out == 1'b1, "R3 latched / R10 bit5 no effect", {31'b0, irq_out}, 32'h1);
      // R6 clear while input high: set wins
      bus_write(32'h00, 32'h0);
      bus_read(32'h00, rd); check(rd == 32'h10, "R6 set wins", rd, 32'h10);
      // R7 sticky after input drops
      irq_in = 32'h0;
      tick(5);
      bus_read(32'h00, rd); check(rd == 32'h10, "R7 sticky", rd, 32'h10);
      // R5 clear-all
      bus_write(32'h00, 32'h0);
      bus_read(32'h00, rd); check(rd == 32'h0, "R5 clear all", rd, 32'h0);

      // R5 partial acknowledge
      irq_in = 32'h6; tick(3); irq_in = 32'h0; tick(3);
      bus_write(32'h00, ~32'h2);
      bus_read(32'h00, rd); check(rd == 32'h4, "R5 partial clear", rd, 32'h4);
      bus_write(32'h00, 32'h0);

      // R4 edge mode: held input does not re-set
      bus_write(32'h28, 32'h08);
      irq_in = 32'h80; tick(4);
      bus_read(32'h00, rd); check(rd == 32'h80, "R4 edge set", rd, 32'h80);
      bus_write(32'h00, 32'h0);
      tick(4);
      bus_read(32'h00, rd); check(rd == 32'h0, "R4 no re-set while held", rd, 32'h0);
      irq_in = 32'h0; tick(3);
      irq_in = 32'h80; tick(4);
      bus_read(32'h00, rd); check(rd == 32'h80, "R4 second edge", rd, 32'h80);
      irq_in = 32'h0;
      bus_write(32'h00, 32'h0);

      // R8 masked source still latches, output gated
      bus_write(32'h10, 32'h200);
      irq_in = 32'h200; tick(4); irq_in = 32'h0;
      check(irq_out == 1'b0, "R8 masked output", {31'b0, irq_out}, 32'h0);
      bus_read(32'h00, rd); check(rd == 32'h200, "R8 masked latch", rd, 32'h200);
      bus_write(32'h10, 32'h0);
      tick(1); check(irq_out == 1'b1, "R8 unmask", {31'b0, irq_out}, 32'h1);
      bus_write(32'h00, 32'h0);

      // random phase, checked by the model every cycle (R3 R4 R5 R6 R9 R1)
      for (int i = 0; i < 4000; i++) begin
         int unsigned pick;
         @(negedge clk);
         irq_in = $urandom & $urandom;
         pick = $urandom_range(0, 15);
         if (pick < 6) begin
            req_valid = 1'b1;
            req_write = ($urandom_range(0, 1) == 1);
            case ($urandom_range(0, 4))
               0: req_addr = 32'h00;
               1: req_addr = 32'h10;
               2: req_addr = 32'h28;
               3: req_addr = 32'h00;
               default: req_addr = 32'h08;
            endcase
            req_wdata = (req_addr == 32'h00) ? ($urandom | $urandom) : $urandom;
         end else begin
            req_valid = 1'b0; req_write = 1'b0;
         end
      end
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; irq_in = '0;
      tick(2);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule